// File: doc/BRIEF.md
# Connection Memory Block Initializer

This block owns a 16-bit-wide connection memory and can fill all of it in one hardware pass. Software first raises a mode bit that permits bulk programming. It then sets a trigger bit that starts the fill. The pattern for the fill is a 5-bit field.

During the pass, each word gets the 5-bit pattern in its top five bits and zeros in its lower eleven bits. The pass writes one location per clock, in ascending address order. It ends when the last location has been written, and the trigger bit then clears itself.

The memory also has a host write path that is used when the block is idle. While a pass runs, a busy indication is high and host writes are discarded. If the mode bit drops in the middle of a pass, the pass stops at once and the trigger bit clears. A registered read port gives the downstream switching logic, or software, access to the memory contents.

Top module: `cmem_init_top`

## Requirements
- R1: After reset, `blk_en` and `busy` are both 0.
- R2: A trigger request (`blk_start`=1) while `prog_mode`=0 is ignored. `blk_en` stays 0 and no memory word changes.
- R3: A trigger request while `prog_mode`=1 and the block is idle sets `blk_en` and `busy` to 1 on the next clock edge.
- R4: Every word written by a pass holds the pattern in bits 15:11 and zeros in bits 10:0.
- R5: A pass writes addresses 0 to DEPTH-1 in ascending order, one per clock. `busy` is high for exactly DEPTH clock cycles.
- R6: After the write to the last location, `blk_en` and `busy` return to 0 on that same edge. No further write happens.
- R7: A host write (`host_we`=1) while `busy`=1 is discarded, and the location keeps the value the pass gives it.
- R8: If `prog_mode` is 0 while a pass runs, no write happens in that cycle and `blk_en` clears at that edge. Locations the pass has not yet reached keep their previous contents.
- R9: When the block is idle, a host write stores `host_wdata` at `host_addr`. A read returns `mem[rd_addr]` on `rd_data` one clock after `rd_addr` is presented.
- R10: The pattern is sampled when the pass starts. Changes to `blk_pattern` during the pass have no effect on the words written.
- R11: A trigger request while a pass is running is ignored. The pass continues without restarting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| prog_mode | input | 1 | Bulk-programming permission bit from the control register |
| blk_start | input | 1 | One-cycle request to set the trigger bit |
| blk_pattern | input | 5 | Pattern written to bits 15:11 |
| blk_en | output | 1 | Trigger bit value, which clears itself at the end of a pass |
| busy | output | 1 | A pass is in progress |
| host_we | input | 1 | Host write strobe |
| host_addr | input | 10 | Host write address |
| host_wdata | input | 16 | Host write data |
| rd_addr | input | 10 | Read address |
| rd_data | output | 16 | Registered read data |

## Verification
The assertions assume that `prog_mode`, `blk_start` and `host_we` are never X after reset. They also assume that a trigger request is a level sampled at each edge rather than an edge-detected event. The stimulus meets these assumptions by driving every input on the falling clock edge from known values. `blk_start` is held for one cycle only, except where the bench deliberately repeats it during a pass to probe R11. Random host data and addresses come from a seeded generator and stay inside the address range, so every expected read value is known to the bench.

// File: rtl/cmi_pkg.sv
package cmi_pkg;
  localparam int WORD_W = 16;
  localparam int PAT_W  = 5;
  localparam int PAT_LSB = WORD_W - PAT_W;

  // Sweep word: pattern in the top bits, zeros elsewhere.
  function automatic logic [WORD_W-1:0] form_word(input logic [PAT_W-1:0] pat);
    logic [WORD_W-1:0] w;
    w = '0;
    w[WORD_W-1:PAT_LSB] = pat;
    return w;
  endfunction
endpackage

// File: rtl/cmi_sweep_ctrl.sv
module cmi_sweep_ctrl #(
  parameter int ADDR_W = 10,
  parameter int PAT_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prog_mode,
  input  logic              blk_start,
  input  logic [PAT_W-1:0]  blk_pattern,
  output logic              en_o,
  output logic              sweep_we,
  output logic              sweep_last,
  output logic [ADDR_W-1:0] sweep_addr,
  output logic [PAT_W-1:0]  pat_o
);
  localparam logic [ADDR_W-1:0] LAST_ADDR = {ADDR_W{1'b1}};

  logic              en_q;
  logic [ADDR_W-1:0] addr_q;
  logic [PAT_W-1:0]  pat_q;
  logic              start_ok;
  logic              abort;

  assign start_ok   = blk_start & prog_mode & ~en_q;
  assign abort      = en_q & ~prog_mode;
  assign sweep_we   = en_q & prog_mode;
  assign sweep_last = sweep_we && (addr_q == LAST_ADDR);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      addr_q <= '0;
      pat_q  <= '0;
    end else if (start_ok) begin
      en_q   <= 1'b1;
      addr_q <= '0;
      pat_q  <= blk_pattern;
    end else if (abort || sweep_last) begin
      en_q   <= 1'b0;
      addr_q <= '0;
    end else if (sweep_we) begin
      addr_q <= addr_q + 1'b1;
    end
  end

  assign en_o       = en_q;
  assign sweep_addr = addr_q;
  assign pat_o      = pat_q;

  AST_START_NEEDS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(en_q) |-> $past(prog_mode)); // R2
  AST_SWEEP_FROM_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(en_q) |-> addr_q == '0); // R3
  AST_SWEEP_ASCEND: assert property (@(posedge clk) disable iff (!rst_n)
    (sweep_we && $past(sweep_we) && $past(en_q)) |-> addr_q == ADDR_W'($past(addr_q) + 1'b1)); // R5
  AST_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    sweep_last |=> !en_q); // R6
  AST_ABORT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && !prog_mode) |=> !en_q); // R8
  AST_PAT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && $past(en_q)) |-> $stable(pat_q)); // R10
endmodule

// File: rtl/cmi_mem.sv
module cmi_mem #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
    rdata <= store[raddr];
  end
endmodule

// File: rtl/cmem_init_top.sv
module cmem_init_top
  import cmi_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prog_mode,
  input  logic              blk_start,
  input  logic [PAT_W-1:0]  blk_pattern,
  output logic              blk_en,
  output logic              busy,
  input  logic              host_we,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [WORD_W-1:0] host_wdata,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [WORD_W-1:0] rd_data
);
  logic              en_w;
  logic              sweep_we;
  logic              sweep_last;
  logic [ADDR_W-1:0] sweep_addr;
  logic [PAT_W-1:0]  pat_w;
  logic              host_commit;
  logic              mem_we;
  logic [ADDR_W-1:0] mem_addr;
  logic [WORD_W-1:0] mem_wdata;
  logic [WORD_W-1:0] sweep_word;

  cmi_sweep_ctrl #(.ADDR_W(ADDR_W), .PAT_W(PAT_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .prog_mode  (prog_mode),
    .blk_start  (blk_start),
    .blk_pattern(blk_pattern),
    .en_o       (en_w),
    .sweep_we   (sweep_we),
    .sweep_last (sweep_last),
    .sweep_addr (sweep_addr),
    .pat_o      (pat_w)
  );

  assign sweep_word  = form_word(pat_w);
  assign host_commit = host_we & ~en_w;
  assign mem_we      = sweep_we | host_commit;
  assign mem_addr    = sweep_we ? sweep_addr : host_addr;
  assign mem_wdata   = sweep_we ? sweep_word : host_wdata;

  cmi_mem #(.ADDR_W(ADDR_W), .DATA_W(WORD_W)) u_mem (
    .clk  (clk),
    .we   (mem_we),
    .waddr(mem_addr),
    .wdata(mem_wdata),
    .raddr(rd_addr),
    .rdata(rd_data)
  );

  assign blk_en = en_w;
  assign busy   = en_w;

  AST_RESET_IDLE: assert property (@(posedge clk)
    !rst_n |=> !blk_en && !busy); // R1
  AST_WORD_FORMAT: assert property (@(posedge clk) disable iff (!rst_n)
    sweep_we |-> mem_wdata[PAT_LSB-1:0] == '0); // R4
  AST_HOST_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !host_commit); // R7
  AST_NO_WRITE_ON_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !prog_mode) |-> !mem_we); // R8
endmodule

// File: tb/tb_cmem_init_top.sv
module tb_cmem_init_top;
  localparam int AW = 10;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst_n;
  logic prog_mode, blk_start, host_we;
  logic [4:0] blk_pattern;
  logic [AW-1:0] host_addr, rd_addr;
  logic [15:0] host_wdata, rd_data;
  logic blk_en, busy;

  int checks = 0;
  int failures = 0;
  logic [AW-1:0] h_addr [8];
  logic [15:0]   h_data [8];

  always #2.5 clk = ~clk;

  cmem_init_top #(.ADDR_W(AW)) dut (
    .clk(clk), .rst_n(rst_n), .prog_mode(prog_mode), .blk_start(blk_start),
    .blk_pattern(blk_pattern), .blk_en(blk_en), .busy(busy),
    .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  function automatic logic [15:0] exp_word(input logic [4:0] p);
    return {p, 11'd0};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [15:0] d);
    rd_addr = a;
    tick();
    d = rd_data;
  endtask

  task automatic hwrite(input logic [AW-1:0] a, input logic [15:0] d);
    host_we = 1'b1; host_addr = a; host_wdata = d;
    tick();
    host_we = 1'b0;
  endtask

  task automatic pulse_start(input logic [4:0] p);
    blk_pattern = p; blk_start = 1'b1;
    tick();
    blk_start = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [15:0] d;
    logic [4:0] pa, pb;
    int busy_cnt;
    int n_ab;
    void'($urandom(32'h5EED));
    rst_n = 1'b0; prog_mode = 1'b0; blk_start = 1'b0; host_we = 1'b0;
    blk_pattern = '0; host_addr = '0; host_wdata = '0; rd_addr = '0;
    tick(); tick();
    rst_n = 1'b1;
    tick();
    check("R1 en", blk_en, 1'b0);
    check("R1 busy", busy, 1'b0);

    // R9: idle host writes and read back
    for (int i = 0; i < 8; i++) begin
      h_addr[i] = AW'(i * 100 + ($urandom % 100));
      h_data[i] = 16'($urandom);
      hwrite(h_addr[i], h_data[i]);
    end
    for (int i = 0; i < 8; i++) begin
      rd(h_addr[i], d);
      check("R9 host readback", d, h_data[i]);
    end

    // R2: start without mode is ignored
    pulse_start(5'h1F);
    check("R2 en stays 0", blk_en, 1'b0);
    tick();
    check("R2 busy stays 0", busy, 1'b0);
    rd(h_addr[3], d);
    check("R2 memory unchanged", d, h_data[3]);

    // R3/R5/R7/R10/R11: full sweep with disturbances
    prog_mode = 1'b1;
    pa = 5'($urandom);
    pulse_start(pa);
    check("R3 en set", blk_en, 1'b1);
    check("R3 busy set", busy, 1'b1);
    busy_cnt = 1;
    while (busy && busy_cnt < 2000) begin
      blk_pattern = ~pa;                          // R10
      if (busy_cnt == 10) begin
        blk_start = 1'b1;                         // R11
      end else begin
        blk_start = 1'b0;
      end
      host_we = (busy_cnt == 600);                // R7
      host_addr = h_addr[7]; host_wdata = ~exp_word(pa);
      tick();
      if (busy) busy_cnt++;
    end
    host_we = 1'b0; blk_start = 1'b0;
    check("R5 busy length", busy_cnt, DEPTH);
    check("R6 en self-clear", blk_en, 1'b0);
    rd('0, d);           check("R4 addr0 word", d, exp_word(pa));
    rd(AW'(DEPTH-1), d); check("R5 last addr word", d, exp_word(pa));
    rd(h_addr[7], d);    check("R7 host write discarded", d, exp_word(pa));
    for (int i = 0; i < 6; i++) begin
      rd(AW'($urandom), d);
      check("R10 sampled pattern", d, exp_word(pa));
    end
    check("R6 still idle", busy, 1'b0);

    // R8: abort mid-sweep with a different pattern
    pb = pa ^ 5'h15;
    n_ab = 200 + ($urandom % 300);
    pulse_start(pb);
    repeat (n_ab) tick();          // writes addresses 0..n_ab-1
    prog_mode = 1'b0;
    tick();
    check("R8 en cleared", blk_en, 1'b0);
    check("R8 busy cleared", busy, 1'b0);
    rd(AW'(n_ab-1), d); check("R8 reached addr", d, exp_word(pb));
    rd(AW'(n_ab), d);   check("R8 untouched addr", d, exp_word(pa));
    rd(AW'(DEPTH-1), d); check("R8 tail untouched", d, exp_word(pa));

    // R9: idle host write after abort
    hwrite(AW'(5), 16'hA5C3);
    rd(AW'(5), d); check("R9 write after abort", d, 16'hA5C3);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule